// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits on the compute-unit side of a load/store memory port. An upstream unit hands it one command at a time, made of an operation (load or store), an address, a byte length and, for stores, the write data. The requester raises the matching request line toward the memory-side port and holds the address and length steady. It then waits for the port to either acknowledge the address or signal an exception. The acknowledge is a promise that the access will complete. For a load, it captures the returned word on the single cycle the port presents it. For a store, it issues a one-cycle data strobe. It then reports the outcome upstream with a one-cycle done pulse that carries a fault bit.

The requester also handles byte lanes within the 64-bit data word. The low three address bits pick the starting lane. The effective byte count is the 4-bit length, capped at 8. Store data is shifted up into its lanes and comes with a byte-enable mask. Returned load data is shifted down, right-aligned and masked. Bytes that would run past the top of the word are dropped; splitting misaligned accesses is left to other logic.

The state machine has six states:

- IDLE: takes a command when it is valid, the port's busy input is low, and abort is low.
- REQ_WAIT_ACK: drives the request, address and length. An exception moves it to DONE with the fault bit set. An acknowledge moves it to LD_WAIT_DATA for a load or to ST_SEND for a store.
- LD_WAIT_DATA: keeps the request up. The load-valid strobe moves it to DONE and captures the data. An exception moves it to DONE with the fault bit set.
- ST_SEND: drives the store strobe for one cycle, then moves to ST_WAIT_IDLE.
- ST_WAIT_IDLE: drops the request lines and moves to DONE once busy reads low.
- DONE: pulses done, then returns to IDLE.

The abort input forces IDLE from any state at the next clock.

Top module: `lsport_requester`

## Requirements
- R1: After reset the block is in IDLE. No request line, address-valid, store strobe or done is high, and `cmd_ready_o` is high while `port_busy_i` is low.
- R2: `cmd_ready_o` is high only in IDLE with `port_busy_i` low. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high.
- R3: From the cycle after a command is taken until busy drops, the requester drives the following. `port_ld_req_o` is high for a load and `port_st_req_o` is high for a store, never both at once. `port_addr_valid_o` is high. `port_addr_o` and `port_len_o` equal the command's address and length and stay constant.
- R4: An exception pulse seen in REQ_WAIT_ACK or LD_WAIT_DATA ends the operation. Done pulses on the next cycle with `fault_o`=1 and `rdata_o`=0. All request lines are low in that cycle. No store strobe is ever issued for that command. An exception wins over an acknowledge in the same cycle.
- R5: A load waits in LD_WAIT_DATA for any number of cycles after the acknowledge. It captures data only on the cycle `port_ld_valid_i` is high. Done pulses the next cycle with `fault_o`=0.
- R6: Load result: let n = min(len, 8) and lane = addr[2:0]. `rdata_o` holds port bytes lane to lane+n-1 of the returned word in its bytes 0 to n-1. All other bytes are zero, including bytes that would fall past byte 7.
- R7: `port_st_valid_o` is high for exactly one cycle. That cycle is the one right after the cycle where the acknowledge was high. It is never high before an acknowledge.
- R8: During the store strobe, `port_st_data_o` holds the low n bytes of the write data shifted up by lane bytes, and all other bytes are zero. Bit i of `port_st_be_o` is set exactly when byte i is written, truncated at bit 7, so a length of 0 gives a mask of 0.
- R9: After the strobe cycle, the request lines are low. With a port that drops busy on the cycle after the strobe, done pulses two cycles after the strobe cycle with `fault_o`=0 and `rdata_o`=0.
- R10: Done is high for one cycle per completed command. It occurs exactly at the completion cycle stated in R4, R5 or R9.
- R11: When `abort_i` is high, the next clock returns the block to IDLE. In that cycle the request lines, address-valid, store strobe and done are all low. No done pulse follows for the aborted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Return to IDLE at the next clock |
| cmd_valid_i | input | 1 | Upstream command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_is_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Byte address |
| cmd_len_i | input | LEN_W | Byte count (capped at 8) |
| cmd_wdata_i | input | DATA_W | Store data, right-aligned |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Operation ended by exception (valid with done) |
| rdata_o | output | DATA_W | Aligned load result (valid with done) |
| port_ld_req_o | output | 1 | Load request to port |
| port_st_req_o | output | 1 | Store request to port |
| port_addr_valid_o | output | 1 | Address valid to port |
| port_addr_o | output | ADDR_W | Held address |
| port_len_o | output | LEN_W | Held length |
| port_busy_i | input | 1 | Port busy |
| port_addr_ack_i | input | 1 | One-cycle address acknowledge |
| port_exc_i | input | 1 | One-cycle exception pulse |
| port_ld_valid_i | input | 1 | One-cycle load data strobe |
| port_ld_data_i | input | DATA_W | Load data word |
| port_st_valid_o | output | 1 | One-cycle store data strobe |
| port_st_data_o | output | DATA_W | Lane-aligned store data |
| port_st_be_o | output | DATA_W/8 | Store byte enables |

## Verification
The bench builds the block with a 16-bit address, the 64-bit word and the 4-bit length. The narrow address keeps the responder's memory model cheap, while every one of the eight byte lanes and every length from 0 to 15 stays reachable. Lengths above 8 exercise the cap, and late lanes combined with long lengths exercise the truncation at the top of the word. The behavioural responder draws acknowledge and load-data delays of zero to three cycles, injects exceptions into loads and stores, and holds one acknowledge back long enough to abort the command mid-wait.

// File: rtl/lsreq_pkg.sv
package lsreq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_WAIT_ACK,
        S_LD_WAIT_DATA,
        S_ST_SEND,
        S_ST_WAIT_IDLE,
        S_DONE
    } lsreq_state_e;

    // number of address bits that select a byte inside one data word
    function automatic int unsigned lane_bits(int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/lsreq_cmd_reg.sv
module lsreq_cmd_reg #(
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              is_store_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              is_store_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] wdata_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_store_o <= 1'b0;
            addr_o     <= '0;
            len_o      <= '0;
            wdata_o    <= '0;
        end else if (load_i) begin
            is_store_o <= is_store_i;
            addr_o     <= addr_i;
            len_o      <= len_i;
            wdata_o    <= wdata_i;
        end
    end

endmodule

// File: rtl/lsreq_lane.sv
module lsreq_lane #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input  logic [lsreq_pkg::lane_bits(DATA_W)-1:0] lane_i,
    input  logic [LEN_W-1:0]                        len_i,
    input  logic [DATA_W-1:0]                       wdata_i,
    input  logic [DATA_W-1:0]                       raw_i,
    output logic [DATA_W-1:0]                       st_data_o,
    output logic [DATA_W/8-1:0]                     st_be_o,
    output logic [DATA_W-1:0]                       ld_data_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int LANE_W = lsreq_pkg::lane_bits(DATA_W);
    localparam int SH_W   = LANE_W + 3;

    logic [LEN_W:0]      n_eff;
    logic [NBYTES-1:0]   keep;
    logic [DATA_W-1:0]   bmask;
    logic [SH_W-1:0]     sh;

    // clamp the byte count to one word
    always_comb begin
        if ({1'b0, len_i} > (LEN_W+1)'(NBYTES)) n_eff = (LEN_W+1)'(NBYTES);
        else                                    n_eff = {1'b0, len_i};
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign keep[i]          = (n_eff > (LEN_W+1)'(i));
        assign bmask[i*8 +: 8]  = {8{keep[i]}};
    end

    assign sh        = {lane_i, 3'b000};
    assign st_data_o = (wdata_i & bmask) << sh;
    assign st_be_o   = keep << lane_i;
    assign ld_data_o = (raw_i >> sh) & bmask;

endmodule

// File: rtl/lsreq_fsm.sv
module lsreq_fsm
    import lsreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic cmd_valid_i,
    input  logic op_store_i,
    input  logic port_busy_i,
    input  logic port_addr_ack_i,
    input  logic port_exc_i,
    input  logic port_ld_valid_i,
    output logic cmd_ready_o,
    output logic cmd_take_o,
    output logic hold_o,
    output logic ld_req_o,
    output logic st_req_o,
    output logic st_strobe_o,
    output logic ld_capture_o,
    output logic done_o,
    output logic fault_o
);

    lsreq_state_e state_q, state_d;
    logic         fault_q, fault_d;
    logic         idle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_take_o) begin
                    state_d = S_REQ_WAIT_ACK;
                    fault_d = 1'b0;
                end
            end
            S_REQ_WAIT_ACK: begin
                if (port_exc_i) begin
                    state_d = S_DONE;
                    fault_d = 1'b1;
                end else if (port_addr_ack_i) begin
                    state_d = op_store_i ? S_ST_SEND : S_LD_WAIT_DATA;
                end
            end
            S_LD_WAIT_DATA: begin
                if (port_exc_i) begin
                    state_d = S_DONE;
                    fault_d = 1'b1;
                end else if (port_ld_valid_i) begin
                    state_d = S_DONE;
                end
            end
            S_ST_SEND:      state_d = S_ST_WAIT_IDLE;
            S_ST_WAIT_IDLE: if (!port_busy_i) state_d = S_DONE;
            S_DONE:         state_d = S_IDLE;
            default:        state_d = S_IDLE;
        endcase
        if (abort_i) state_d = S_IDLE;
    end

    // outputs
    always_comb begin
        idle        = 1'b0;
        hold_o      = 1'b0;
        st_strobe_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            S_IDLE:                         idle = 1'b1;
            S_REQ_WAIT_ACK, S_LD_WAIT_DATA: hold_o = 1'b1;
            S_ST_SEND: begin
                hold_o      = 1'b1;
                st_strobe_o = 1'b1;
            end
            S_ST_WAIT_IDLE:                 ;
            S_DONE:                         done_o = 1'b1;
            default:                        ;
        endcase
    end

    assign ld_req_o     = hold_o & ~op_store_i;
    assign st_req_o     = hold_o & op_store_i;
    assign cmd_ready_o  = idle & ~port_busy_i;
    assign cmd_take_o   = cmd_ready_o & cmd_valid_i & ~abort_i;
    assign ld_capture_o = (state_q == S_LD_WAIT_DATA) & port_ld_valid_i
                        & ~port_exc_i & ~abort_i;
    assign fault_o      = fault_q;

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_req_o && st_req_o));

    // R2
    ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !port_busy_i);

    // R7
    strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_strobe_o |-> $past(port_addr_ack_i));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_strobe_o |=> !st_strobe_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    exc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_REQ_WAIT_ACK || state_q == S_LD_WAIT_DATA)
         && port_exc_i && !abort_i) |=> (done_o && fault_o && !hold_o));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !(ld_req_o || st_req_o || hold_o || st_strobe_o || done_o));

endmodule

// File: rtl/lsport_requester.sv
module lsport_requester #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort_i,
    input  logic                cmd_valid_i,
    output logic                cmd_ready_o,
    input  logic                cmd_is_store_i,
    input  logic [ADDR_W-1:0]   cmd_addr_i,
    input  logic [LEN_W-1:0]    cmd_len_i,
    input  logic [DATA_W-1:0]   cmd_wdata_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                port_ld_req_o,
    output logic                port_st_req_o,
    output logic                port_addr_valid_o,
    output logic [ADDR_W-1:0]   port_addr_o,
    output logic [LEN_W-1:0]    port_len_o,
    input  logic                port_busy_i,
    input  logic                port_addr_ack_i,
    input  logic                port_exc_i,
    input  logic                port_ld_valid_i,
    input  logic [DATA_W-1:0]   port_ld_data_i,
    output logic                port_st_valid_o,
    output logic [DATA_W-1:0]   port_st_data_o,
    output logic [DATA_W/8-1:0] port_st_be_o
);

    localparam int LANE_W = lsreq_pkg::lane_bits(DATA_W);

    logic              take;
    logic              capture;
    logic              op_store;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] ld_aligned;
    logic [DATA_W-1:0] rdata_q;

    lsreq_cmd_reg #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (take),
        .is_store_i (cmd_is_store_i),
        .addr_i     (cmd_addr_i),
        .len_i      (cmd_len_i),
        .wdata_i    (cmd_wdata_i),
        .is_store_o (op_store),
        .addr_o     (addr_q),
        .len_o      (len_q),
        .wdata_o    (wdata_q)
    );

    lsreq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .abort_i         (abort_i),
        .cmd_valid_i     (cmd_valid_i),
        .op_store_i      (op_store),
        .port_busy_i     (port_busy_i),
        .port_addr_ack_i (port_addr_ack_i),
        .port_exc_i      (port_exc_i),
        .port_ld_valid_i (port_ld_valid_i),
        .cmd_ready_o     (cmd_ready_o),
        .cmd_take_o      (take),
        .hold_o          (port_addr_valid_o),
        .ld_req_o        (port_ld_req_o),
        .st_req_o        (port_st_req_o),
        .st_strobe_o     (port_st_valid_o),
        .ld_capture_o    (capture),
        .done_o          (done_o),
        .fault_o         (fault_o)
    );

    lsreq_lane #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_lane (
        .lane_i    (addr_q[LANE_W-1:0]),
        .len_i     (len_q),
        .wdata_i   (wdata_q),
        .raw_i     (port_ld_data_i),
        .st_data_o (port_st_data_o),
        .st_be_o   (port_st_be_o),
        .ld_data_o (ld_aligned)
    );

    // result register: cleared when a command is taken, filled on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (take)    rdata_q <= '0;
        else if (capture) rdata_q <= ld_aligned;
    end

    assign port_addr_o = addr_q;
    assign port_len_o  = len_q;
    assign rdata_o     = rdata_q;

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr_valid_o && $past(port_addr_valid_o))
            |-> ($stable(port_addr_o) && $stable(port_len_o)));

    // R9
    store_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_st_valid_o |=> !(port_st_req_o || port_ld_req_o || port_addr_valid_o));

endmodule

// File: tb/lsport_requester_bench.sv
module lsport_requester_bench;

    localparam int AW   = 16;
    localparam int DW   = 64;
    localparam int LW   = 4;
    localparam int NCMD = 210;
    localparam longint WATCHDOG = 20000;

    typedef struct {
        bit              st;
        logic [AW-1:0]   addr;
        logic [LW-1:0]   len;
        logic [DW-1:0]   wd;
        bit              exc;
        bit              abrt;
        int              ackd;
        int              datd;
    } cmd_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          abort_i = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_is_store = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          done, fault;
    logic [DW-1:0] rdata;
    logic          ld_req, st_req, av;
    logic [AW-1:0] p_addr;
    logic [LW-1:0] p_len;
    logic          bsy = 1'b0, ack = 1'b0, exc = 1'b0, ldv = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic          stv;
    logic [DW-1:0] st_data;
    logic [7:0]    st_be;

    lsport_requester #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_lsport_requester (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_is_store_i(cmd_is_store), .cmd_addr_i(cmd_addr),
        .cmd_len_i(cmd_len), .cmd_wdata_i(cmd_wdata),
        .done_o(done), .fault_o(fault), .rdata_o(rdata),
        .port_ld_req_o(ld_req), .port_st_req_o(st_req),
        .port_addr_valid_o(av), .port_addr_o(p_addr), .port_len_o(p_len),
        .port_busy_i(bsy), .port_addr_ack_i(ack), .port_exc_i(exc),
        .port_ld_valid_i(ldv), .port_ld_data_i(ld_data),
        .port_st_valid_o(stv), .port_st_data_o(st_data), .port_st_be_o(st_be)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return 64'h0123456789ABCDEF ^ ({48'b0, a} * 64'h9E3779B97F4A7C15);
    endfunction

    function automatic int nb(logic [LW-1:0] len);
        return (int'(len) > 8) ? 8 : int'(len);
    endfunction

    function automatic logic [DW-1:0] bmask(int n);
        return (n >= 8) ? '1 : ((64'd1 << (n * 8)) - 64'd1);
    endfunction

    function automatic logic [DW-1:0] exp_ld(logic [DW-1:0] w, logic [AW-1:0] a, logic [LW-1:0] len);
        return (w >> (int'(a[2:0]) * 8)) & bmask(nb(len));
    endfunction

    function automatic logic [DW-1:0] exp_st(logic [DW-1:0] w, logic [AW-1:0] a, logic [LW-1:0] len);
        return (w & bmask(nb(len))) << (int'(a[2:0]) * 8);
    endfunction

    function automatic logic [7:0] exp_be(logic [AW-1:0] a, logic [LW-1:0] len);
        logic [15:0] b;
        b = ((16'd1 << nb(len)) - 16'd1) << int'(a[2:0]);
        return b[7:0];
    endfunction

    function automatic cmd_t gen(int i);
        cmd_t c;
        c.st   = 1'b0;
        c.addr = AW'($urandom);
        c.len  = LW'($urandom_range(15));
        c.wd   = {$urandom, $urandom};
        c.exc  = 1'b0;
        c.abrt = 1'b0;
        c.ackd = int'($urandom_range(3));
        c.datd = int'($urandom_range(3));
        case (i)
            0: begin c.addr = 16'h0100; c.len = 4'd8;  c.ackd = 0; c.datd = 0; end
            1: begin c.addr = 16'h0107; c.len = 4'd1;  c.ackd = 2; c.datd = 3; end
            2: begin c.addr = 16'h0213; c.len = 4'd15; end
            3: begin c.st = 1'b1; c.addr = 16'h0322; c.len = 4'd4;
                     c.wd = 64'h1122334455667788; c.ackd = 1; end
            4: begin c.st = 1'b1; c.addr = 16'h0405; c.len = 4'd0; end
            5: begin c.st = 1'b1; c.addr = 16'h0505; c.len = 4'd12; end
            6: begin c.exc = 1'b1; c.ackd = 1; end
            7: begin c.st = 1'b1; c.exc = 1'b1; c.ackd = 0; end
            8: begin c.abrt = 1'b1; c.ackd = 10; end
            9: begin c.exc = 1'b1; c.ackd = 0; end
            default: begin
                c.st  = bit'($urandom_range(1));
                c.exc = ($urandom_range(5) == 0);
            end
        endcase
        return c;
    endfunction

    cmd_t   q[$];
    cmd_t   cur;
    cmd_t   op;
    int     rs = 0;
    int     rcnt = 0;
    int     rwait = 0;
    longint cyc = 0;
    longint exp_done_cyc = -10;
    longint exc_cyc = -10;
    longint ack_cyc = -10;
    longint abort_chk_cyc = -10;
    bit              exp_fault = 1'b0;
    logic [DW-1:0]   exp_rdata = '0;
    bit              exp_is_st = 1'b0;
    int     idx = 0;
    int     gap = 0;
    bit     pending = 1'b0;
    logic          prev_bsy = 1'b0, prev_ld = 1'b0, prev_st = 1'b0, prev_av = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [LW-1:0] prev_len = '0;

    initial begin
        // reset phase
        repeat (3) @(negedge clk);
        // R1 outputs idle during reset
        chk(!ld_req && !st_req && !av && !stv && !done, "R1", "request/strobe/done in reset",
            {59'b0, ld_req, st_req, av, stv, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle and ready after reset
        chk(!ld_req && !st_req && !av && !stv && !done, "R1", "outputs after reset",
            {59'b0, ld_req, st_req, av, stv, done}, '0);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", {63'b0, cmd_ready}, 64'd1);

        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
                break;
            end

            // step 1: outputs of this cycle
            if (done || cyc == exp_done_cyc) begin
                chk(done && cyc == exp_done_cyc, "R10", "done timing",
                    {63'b0, done}, {63'b0, cyc == exp_done_cyc});
                if (done && cyc == exp_done_cyc) begin
                    if (exp_fault) begin
                        chk(fault == 1'b1, "R4", "fault bit", {63'b0, fault}, 64'd1);
                        chk(rdata == '0, "R4", "rdata on fault", rdata, '0);
                    end else if (exp_is_st) begin
                        chk(fault == 1'b0, "R9", "store fault bit", {63'b0, fault}, '0);
                        chk(rdata == '0, "R9", "rdata on store", rdata, '0);
                    end else begin
                        chk(fault == 1'b0, "R5", "load fault bit", {63'b0, fault}, '0);
                        chk(rdata == exp_rdata, "R6", "load result", rdata, exp_rdata);
                    end
                end
            end
            if (cyc == abort_chk_cyc) begin
                // R11 all quiet one clock after abort
                chk(!ld_req && !st_req && !av && !stv && !done, "R11", "lines after abort",
                    {59'b0, ld_req, st_req, av, stv, done}, '0);
            end
            if (cyc == exc_cyc + 1) begin
                // R4 requests dropped after exception
                chk(!ld_req && !st_req && !av, "R4", "lines after exception",
                    {61'b0, ld_req, st_req, av}, '0);
            end
            if (ld_req && st_req) chk(1'b0, "R3", "both request lines", 64'd3, 64'd1);
            if (stv) begin
                chk(rs == 3 && ack_cyc == cyc - 1, "R7", "strobe placement",
                    64'(cyc - ack_cyc), 64'd1);
                if (rs == 3) begin
                    chk(st_data == exp_st(q[0].wd, q[0].addr, q[0].len), "R8", "store data",
                        st_data, exp_st(q[0].wd, q[0].addr, q[0].len));
                    chk(st_be == exp_be(q[0].addr, q[0].len), "R8", "byte enables",
                        {56'b0, st_be}, {56'b0, exp_be(q[0].addr, q[0].len)});
                end
            end else if (rs == 3) begin
                chk(1'b0, "R7", "strobe missing", 64'd0, 64'd1);
            end
            if (rs >= 1 && rs <= 3 && q.size() > 0) begin
                chk(ld_req == !q[0].st && st_req == q[0].st && av, "R3", "request lines",
                    {61'b0, ld_req, st_req, av}, {61'b0, !q[0].st, q[0].st, 1'b1});
                chk(p_addr == q[0].addr && p_len == q[0].len, "R3", "address/length",
                    {44'b0, p_len, p_addr}, {44'b0, q[0].len, q[0].addr});
            end

            // step 2: responder
            abort_i = 1'b0;
            ack = 1'b0;
            exc = 1'b0;
            ldv = 1'b0;
            ld_data = {$urandom, $urandom};
            begin
                int rs0;
                rs0 = rs;
                if (rs0 == 0 && (ld_req || st_req)) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R3", "request without command", 64'd1, 64'd0);
                    end else begin
                        op = q[0];
                        bsy = 1'b1;
                        rs = 1;
                        rcnt = op.ackd;
                        rwait = 0;
                        rs0 = 1;
                    end
                end
                if (rs0 == 1) begin
                    if (op.abrt && rwait == 2) begin
                        abort_i = 1'b1;
                        bsy = 1'b0;
                        rs = 0;
                        void'(q.pop_front());
                        abort_chk_cyc = cyc + 1;
                    end else if (rcnt == 0) begin
                        if (op.exc) begin
                            exc = 1'b1;
                            bsy = 1'b0;
                            rs = 0;
                            exp_done_cyc = cyc + 1;
                            exp_fault = 1'b1;
                            exp_is_st = op.st;
                            exp_rdata = '0;
                            exc_cyc = cyc;
                            void'(q.pop_front());
                        end else begin
                            ack = 1'b1;
                            ack_cyc = cyc;
                            rs = op.st ? 3 : 2;
                            rcnt = op.datd;
                        end
                    end else begin
                        rcnt--;
                    end
                    rwait++;
                end else if (rs0 == 2) begin
                    if (rcnt == 0) begin
                        ldv = 1'b1;
                        ld_data = mem_word(op.addr);
                        bsy = 1'b0;
                        rs = 0;
                        exp_done_cyc = cyc + 1;
                        exp_fault = 1'b0;
                        exp_is_st = 1'b0;
                        exp_rdata = exp_ld(mem_word(op.addr), op.addr, op.len);
                        void'(q.pop_front());
                    end else begin
                        rcnt--;
                    end
                end else if (rs0 == 3) begin
                    rs = 4;
                end else if (rs0 == 4) begin
                    bsy = 1'b0;
                    rs = 0;
                    exp_done_cyc = cyc + 1;
                    exp_fault = 1'b0;
                    exp_is_st = 1'b1;
                    exp_rdata = '0;
                    void'(q.pop_front());
                end
            end

            // step 3: request lines stay put while busy
            if (bsy && prev_bsy) begin
                chk(ld_req == prev_ld && st_req == prev_st && av == prev_av &&
                    p_addr == prev_addr && p_len == prev_len, "R3", "stable while busy",
                    {41'b0, p_len, p_addr, ld_req, st_req, av},
                    {41'b0, prev_len, prev_addr, prev_ld, prev_st, prev_av});
            end
            prev_bsy = bsy;
            prev_ld = ld_req;
            prev_st = st_req;
            prev_av = av;
            prev_addr = p_addr;
            prev_len = p_len;

            // step 4: command driver
            if (pending) begin
                pending = 1'b0;
                cmd_valid = 1'b0;
            end
            if (!cmd_valid && idx < NCMD) begin
                if (gap > 0) begin
                    gap--;
                end else begin
                    cur = gen(idx);
                    cmd_is_store = cur.st;
                    cmd_addr = cur.addr;
                    cmd_len = cur.len;
                    cmd_wdata = cur.wd;
                    cmd_valid = 1'b1;
                end
            end

            // step 5: handshake
            #1;
            if (cmd_ready) chk(!bsy, "R2", "ready while busy", {63'b0, bsy}, '0);
            if (cmd_valid && cmd_ready && !abort_i) begin
                pending = 1'b1;
                q.push_back(cur);
                idx++;
                gap = (idx < 10) ? 0 : int'($urandom_range(2));
            end

            if (idx >= NCMD && !cmd_valid && !pending && q.size() == 0 && rs == 0 &&
                cyc > exp_done_cyc + 2 && cyc > abort_chk_cyc + 1) break;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule